// File: doc/BRIEF.md
# Tag-only cache hit/miss profiler

This block watches a stream of memory addresses and models a set-associative cache that keeps tags but no data. For every accepted address it looks up the indexed set and reports one result code one cycle later: a hit, a miss that filled a free line, or a miss that had to evict a line. It also keeps saturating totals of hits, misses and evictions. Designers use it next to a traffic source to measure how a cache geometry would behave, without building the data path.

Address bits split from the bottom up. `OFS_BITS` bits of byte offset are ignored. `SET_BITS` bits select one of 2^SET_BITS sets. The rest of the address is the tag. Each set holds `WAYS` lines, and `WAYS=1` gives a direct-mapped cache. Replacement is least-recently-used. Each line keeps a recency rank from 0 (newest) to WAYS-1 (oldest), and the ranks in a set always form a permutation. The defaults model 64-bit addresses, 32 sets of 32-byte lines, direct-mapped: 1 KB of modeled capacity.

The address input is a valid/ready port. `in_ready` is low only while `rst` is high, so the block applies no other back-pressure. An address is taken on every rising edge where both `in_valid` and `in_ready` are high. `in_addr` must be held stable and known while `in_valid` is high. The result port has no ready: it shows each result for exactly one cycle, and the counters change in that same cycle.

Top module: `tagcache_prof`

## Requirements
- R1: Lookup uses only the set index `in_addr[OFS_BITS +: SET_BITS]` and the tag `in_addr[ADDR_W-1 : OFS_BITS+SET_BITS]`. Two addresses that differ only in the low `OFS_BITS` bits map to the same line, and sets are independent of each other.
- R2: An access is a hit when a valid line in the indexed set holds the same tag. A hit reports code 2'b01, and that line becomes the most recently used.
- R3: A miss in a set that still has an invalid line fills the lowest-numbered invalid line and reports code 2'b10 (miss, no eviction).
- R4: A miss in a set whose lines are all valid replaces the least recently used line and reports code 2'b11. This outcome counts as both a miss and an eviction.
- R5: Recency ranks within a set stay a permutation of 0..WAYS-1. The touched line gets rank 0, and every line whose rank was below the touched line's old rank moves up by one.
- R6: Each accepted address produces `res_valid` high for exactly one cycle, on the cycle after the accepting edge. `res_valid` is low, and `res_code` is 2'b00, in any cycle that follows an edge with no acceptance.
- R7: `hit_count` rises by one for each code 2'b01. `miss_count` rises by one for each code 2'b10 or 2'b11. `evict_count` rises by one for each code 2'b11. Each count changes in the same cycle its result is shown.
- R8: Every counter saturates at 2^CNT_W-1 and never wraps.
- R9: A synchronous reset (`rst` high at a rising edge) invalidates every line, clears all three counters and clears `res_valid`. After reset, any address misses.
- R10: `in_ready` is low while `rst` is high and high otherwise.
- R11: With `WAYS=1`, two tags that share a set evict each other on every alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Block can take an address |
| in_addr | input | ADDR_W | Byte address of the access |
| res_valid | output | 1 | Result shown this cycle |
| res_code | output | 2 | 01 hit, 10 miss, 11 miss with eviction, 00 idle |
| hit_count | output | CNT_W | Saturating hit total |
| miss_count | output | CNT_W | Saturating miss total |
| evict_count | output | CNT_W | Saturating eviction total |

## Verification
Errors in the tag/valid arrays are visible on the very next access to the affected set. A lost fill turns an expected hit into a miss, and a stale valid bit turns a free-line miss (10) into an eviction (11). Errors in the recency ranks stay hidden until the set is full. They appear only when a later conflict evicts the wrong line and a re-access of the line that should have survived returns 11 instead of 01. The directed sequences therefore fill a set, reorder it with hits, and re-probe each line after every eviction. Counter errors show on the same cycle as the result that should have moved them.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  typedef enum logic [1:0] {
    RES_IDLE  = 2'b00,
    RES_HIT   = 2'b01,
    RES_MISS  = 2'b10,
    RES_EVICT = 2'b11
  } res_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tcp_way_match.sv
module tcp_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 32,
  parameter int unsigned IDX_W = 2
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0][IDX_W-1:0]  ages,
  input  logic [TAG_W-1:0]            tag_in,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic                        full,
  output logic [IDX_W-1:0]            sel_way
);

  logic [IDX_W-1:0] hit_idx, inv_idx, lru_idx;
  logic             any_inv;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == tag_in);
  end

  always_comb begin
    hit_idx = '0;
    inv_idx = '0;
    lru_idx = '0;
    any_inv = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (ages[i] == IDX_W'(WAYS - 1)) lru_idx = IDX_W'(i);
    end
    // scan downward so the lowest free way wins
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        inv_idx = IDX_W'(i);
        any_inv = 1'b1;
      end
    end
  end

  assign hit     = |hit_vec;
  assign full    = !any_inv;
  assign sel_way = hit ? hit_idx : (any_inv ? inv_idx : lru_idx);

endmodule

// File: rtl/tcp_lru_update.sv
module tcp_lru_update #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [WAYS-1:0][IDX_W-1:0] ages_in,
  input  logic [IDX_W-1:0]           touch,
  output logic [WAYS-1:0][IDX_W-1:0] ages_out
);

  logic [IDX_W-1:0] old_rank;

  always_comb begin
    old_rank = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (IDX_W'(i) == touch) old_rank = ages_in[i];
    end
    for (int i = 0; i < WAYS; i++) begin
      if (IDX_W'(i) == touch)          ages_out[i] = '0;
      else if (ages_in[i] < old_rank)  ages_out[i] = ages_in[i] + 1'b1;
      else                             ages_out[i] = ages_in[i];
    end
  end

endmodule

// File: rtl/tcp_sat_cnt.sv
module tcp_sat_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == TOP));

  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));

endmodule

// File: rtl/tagcache_prof.sv
module tagcache_prof #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned SET_BITS = 5,
  parameter int unsigned OFS_BITS = 5,
  parameter int unsigned WAYS     = 1,
  parameter int unsigned CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);
  import tcp_pkg::*;

  localparam int unsigned SETS  = 1 << SET_BITS;
  localparam int unsigned TAG_W = ADDR_W - SET_BITS - OFS_BITS;
  localparam int unsigned IDX_W = idx_width(WAYS);

  logic [SETS-1:0][WAYS-1:0]             valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][IDX_W-1:0]  age_q;

  logic [SET_BITS-1:0]          set_idx;
  logic [TAG_W-1:0]             tag_in;
  logic                         acc;
  logic [WAYS-1:0]              hit_vec;
  logic                         hit, full;
  logic [IDX_W-1:0]             sel_way;
  logic [WAYS-1:0][IDX_W-1:0]   new_ages;
  res_e                         code_d;
  logic [2:0]                   inc_vec;
  logic [2:0][CNT_W-1:0]        cnt_arr;

  assign in_ready = !rst;
  assign acc      = in_valid && in_ready;
  assign set_idx  = in_addr[OFS_BITS +: SET_BITS];
  assign tag_in   = in_addr[ADDR_W-1 -: TAG_W];

  tcp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .valid   (valid_q[set_idx]),
    .tags    (tag_q[set_idx]),
    .ages    (age_q[set_idx]),
    .tag_in  (tag_in),
    .hit_vec (hit_vec),
    .hit     (hit),
    .full    (full),
    .sel_way (sel_way)
  );

  tcp_lru_update #(.WAYS(WAYS), .IDX_W(IDX_W)) u_lru (
    .ages_in  (age_q[set_idx]),
    .touch    (sel_way),
    .ages_out (new_ages)
  );

  always_comb begin
    if (hit)       code_d = RES_HIT;
    else if (full) code_d = RES_EVICT;
    else           code_d = RES_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      res_valid <= 1'b0;
      res_code  <= RES_IDLE;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= IDX_W'(w);
    end else begin
      res_valid <= acc;
      res_code  <= acc ? code_d : RES_IDLE;
      if (acc) begin
        valid_q[set_idx][sel_way] <= 1'b1;
        tag_q[set_idx][sel_way]   <= tag_in;
        age_q[set_idx]            <= new_ages;
      end
    end
  end

  assign inc_vec[0] = acc && hit;
  assign inc_vec[1] = acc && !hit;
  assign inc_vec[2] = acc && !hit && full;

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    tcp_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (inc_vec[g]),
      .cnt (cnt_arr[g])
    );
  end

  assign hit_count   = cnt_arr[0];
  assign miss_count  = cnt_arr[1];
  assign evict_count = cnt_arr[2];

  // recency ranks of the indexed set stay a permutation
  for (genvar k = 0; k < WAYS; k++) begin : g_perm
    logic [WAYS-1:0] eq_k;
    for (genvar w = 0; w < WAYS; w++) begin : g_eq
      assign eq_k[w] = (age_q[set_idx][w] == IDX_W'(k));
    end
    p_age_perm_r5: assert property (@(posedge clk) disable iff (rst)
      $onehot(eq_k));
  end

  p_tag_unique_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  p_addr_known_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !$isunknown(in_addr));

  p_one_result_r6: assert property (@(posedge clk) disable iff (rst)
    acc |=> res_valid);

  p_no_result_r6: assert property (@(posedge clk) disable iff (rst)
    !acc |=> (!res_valid && res_code == RES_IDLE));

  p_fill_free_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && !hit && !full) |=> (res_code == RES_MISS));

  p_evict_full_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && !hit && full) |=> (res_code == RES_EVICT));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!res_valid && hit_count == '0 && miss_count == '0 && evict_count == '0));

endmodule

// File: tb/sim_tagcache_prof.sv
`timescale 1ns/1ps
module sim_tagcache_prof;

  localparam int C0 = 5;
  localparam logic [C0-1:0] TOP0 = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // u0: 4-way, 4 sets, 16-byte lines, 5-bit counters
  logic        v0 = 1'b0;
  logic [63:0] a0 = '0;
  logic        rd0, rv0;
  logic [1:0]  rc0;
  logic [C0-1:0] h0, m0, e0;

  // u1: default direct-mapped geometry
  logic        v1 = 1'b0;
  logic [63:0] a1 = '0;
  logic        rd1, rv1;
  logic [1:0]  rc1;
  logic [31:0] h1, m1, e1;

  tagcache_prof #(.ADDR_W(64), .SET_BITS(2), .OFS_BITS(4), .WAYS(4), .CNT_W(C0)) u0 (
    .clk(clk), .rst(rst), .in_valid(v0), .in_ready(rd0), .in_addr(a0),
    .res_valid(rv0), .res_code(rc0), .hit_count(h0), .miss_count(m0), .evict_count(e0));

  tagcache_prof u1 (
    .clk(clk), .rst(rst), .in_valid(v1), .in_ready(rd1), .in_addr(a1),
    .res_valid(rv1), .res_code(rc1), .hit_count(h1), .miss_count(m1), .evict_count(e1));

  int xh = 0, xm = 0, xe = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > int'(TOP0)) ? int'(TOP0) : v;
  endfunction

  task automatic acc0(input int tag, input int set, input int ofs, input logic [1:0] code, input string req);
    @(negedge clk);
    v0 = 1'b1;
    a0 = (64'(tag) << 6) | (64'(set) << 4) | 64'(ofs);
    @(negedge clk);
    v0 = 1'b0;
    chk(rv0 == 1'b1, "R6 res_valid", rv0, 1);
    chk(rc0 == code, req, rc0, code);
    if (code == 2'b01) xh = sat(xh + 1);
    else xm = sat(xm + 1);
    if (code == 2'b11) xe = sat(xe + 1);
    chk(h0 == C0'(xh) && m0 == C0'(xm) && e0 == C0'(xe), "R7 counters",
        {h0, m0, e0}, {C0'(xh), C0'(xm), C0'(xe)});
  endtask

  task automatic acc1(input int tag, input int set, input int ofs, input logic [1:0] code, input string req);
    @(negedge clk);
    v1 = 1'b1;
    a1 = (64'(tag) << 10) | (64'(set) << 5) | 64'(ofs);
    @(negedge clk);
    v1 = 1'b0;
    chk(rv1 == 1'b1 && rc1 == code, req, {rv1, rc1}, {1'b1, code});
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(rd0 == 1'b0 && rd1 == 1'b0, "R10 ready low in reset", {rd0, rd1}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd0 == 1'b1 && rd1 == 1'b1, "R10 ready high", {rd0, rd1}, 3);
    chk(rv0 == 1'b0 && rc0 == 2'b00, "R9 no result after reset", {rv0, rc0}, 0);
    chk(h0 == 0 && m0 == 0 && e0 == 0, "R9 counters zero", {h0, m0, e0}, 0);
  endtask

  task automatic t_fill();
    acc0(1, 1, 0, 2'b10, "R3 fill way");
    acc0(2, 1, 3, 2'b10, "R3 fill way");
    acc0(3, 1, 0, 2'b10, "R3 fill way");
    acc0(4, 1, 0, 2'b10, "R3 fill way");
    acc0(1, 1, 5, 2'b01, "R1 R2 hit other offset");
    @(negedge clk);
    chk(rv0 == 1'b0 && rc0 == 2'b00, "R6 idle gives no result", {rv0, rc0}, 0);
  endtask

  task automatic t_lru();
    acc0(5, 1, 0, 2'b11, "R4 evict LRU tag2");
    acc0(2, 1, 0, 2'b11, "R4 evict LRU tag3");
    acc0(4, 1, 0, 2'b01, "R5 tag4 survived");
    acc0(6, 1, 0, 2'b11, "R5 evict tag1");
    acc0(1, 1, 0, 2'b11, "R5 evict tag5");
    acc0(4, 1, 9, 2'b01, "R5 tag4 kept");
    acc0(6, 1, 0, 2'b01, "R5 tag6 kept");
  endtask

  task automatic t_sets();
    acc0(1, 2, 0, 2'b10, "R1 other set free");
    acc0(1, 0, 0, 2'b10, "R1 other set free");
    acc0(1, 2, 15, 2'b01, "R1 set2 hit");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 40; i++) acc0(4, 1, 0, 2'b01, "R8 repeated hit");
    chk(h0 == TOP0, "R8 hit saturates", h0, TOP0);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(rd0 == 1'b0, "R10 ready low in reset", rd0, 0);
    rst = 1'b0;
    xh = 0; xm = 0; xe = 0;
    chk(h0 == 0 && m0 == 0 && e0 == 0 && rv0 == 0, "R9 cleared", {h0, m0, e0, rv0}, 0);
    acc0(4, 1, 0, 2'b10, "R9 lines invalid after reset");
    acc0(4, 1, 0, 2'b01, "R2 hit after refill");
  endtask

  task automatic t_direct();
    acc1(1, 2, 0, 2'b10, "R11 first fill");
    acc1(1, 2, 7, 2'b01, "R11 hit other offset");
    acc1(2, 2, 0, 2'b11, "R11 conflict evicts");
    acc1(1, 2, 0, 2'b11, "R11 conflict evicts back");
    // back-to-back acceptance
    @(negedge clk);
    v1 = 1'b1;
    a1 = (64'(2) << 10) | (64'(2) << 5);
    @(negedge clk);
    chk(rv1 == 1'b1 && rc1 == 2'b11, "R6 back-to-back first", {rv1, rc1}, 7);
    a1 = (64'(3) << 10) | (64'(3) << 5);
    @(negedge clk);
    v1 = 1'b0;
    chk(rv1 == 1'b1 && rc1 == 2'b10, "R6 back-to-back second", {rv1, rc1}, 6);
    @(negedge clk);
    chk(rv1 == 1'b0, "R6 single cycle result", rv1, 0);
    chk(h1 == 1 && m1 == 5 && e1 == 3, "R7 direct-mapped totals", {h1, m1, e1}, {32'd1, 32'd5, 32'd3});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_fill();
    t_lru();
    t_sets();
    t_saturate();
    t_mid_reset();
    t_direct();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule